// File: doc/BRIEF.md
# Rounding Shift and Average Unit

This unit performs signed integer arithmetic on words of XLEN bits (32 or 64). It offers three useful operations: an arithmetic right shift that rounds half-way values upward, with the shift distance taken from a second operand; the same rounding shift with the distance taken from a separate immediate field; and the rounded average of two signed operands. A fourth opcode value is reserved and produces zero.

Each operation is presented with a valid strobe. The result is captured in a register and appears with a valid flag one clock later. The rounding shift adds one at the most significant bit that is shifted out. A shift distance of zero returns the operand unchanged. The shift and the average both compute on XLEN+1 bits, so neither can wrap.

Top module: `round_shift_avg`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid and result are cleared to zero at that edge.
- R2: out_valid is high in exactly the cycle after a cycle in which in_valid was high, so every result is due one clock after its request.
- R3: For the register-shift opcode the shift distance is the low 5 bits of src_b when XLEN is 32, and the low 6 bits when XLEN is 64. Higher bits of src_b have no effect.
- R4: A shift distance of zero returns src_a exactly.
- R5: For a distance s greater than zero, the result is floor((src_a / 2^s) + 1/2), with src_a read as signed. The vacated top bits are copies of the sign bit, and a tie rounds toward plus infinity.
- R6: The immediate-shift opcode takes its distance from imm_amt and gives the same result as the register-shift opcode for an equal distance.
- R7: A non-negative operand never yields a negative shift result. The largest positive value shifted by one gives 2^(XLEN-2).
- R8: The average opcode returns floor((src_a + src_b + 1) / 2) over signed values. The result always lies between the two operands, with no overflow for any pair.
- R9: Opcode encoding on op[1:0]: 2'b00 register shift, 2'b01 immediate shift, 2'b10 average, 2'b11 reserved with result zero.
- R10: In a cycle where in_valid is low, result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe for the current inputs |
| op | input | 2 | Operation select (see R9) |
| src_a | input | XLEN | Signed operand to shift, or first addend of the average |
| src_b | input | XLEN | Signed second addend, or shift distance in its low bits |
| imm_amt | input | XLEN==64 ? 6 : 5 | Immediate shift distance |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | XLEN | Registered signed result |

## Verification
Every operation passes through a single output register, so each result and its valid flag are due on the first rising edge after the request. The bench drives a request on a falling edge and holds it across one rising edge. It then reads out_valid and result at the next falling edge, which is half a cycle after the register loads. For the hold and idle checks, the bench lets further rising edges pass with in_valid low. It then confirms at a falling edge that out_valid has dropped and that result is unchanged.

// File: rtl/rsa_pkg.sv
// Package: shared opcode encoding and width helper for the rounding
// shift / average unit. Assumes XLEN is 32 or 64.
package rsa_pkg;

    typedef enum logic [1:0] {
        OPC_SHR_REG = 2'b00,
        OPC_SHR_IMM = 2'b01,
        OPC_AVG     = 2'b10,
        OPC_NONE    = 2'b11
    } rsa_op_e;

    // Width of the shift-distance field for a given word size.
    function automatic int amt_width(input int xlen);
        return (xlen == 64) ? 6 : 5;
    endfunction

endpackage

// File: rtl/rsa_amount_sel.sv
// Module: picks the shift distance for the current opcode.
// It takes the low bits of src_b for register shifts and the immediate
// field otherwise. It assumes the immediate field already has the
// distance width.
module rsa_amount_sel
    import rsa_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int AW  = amt_width(XLEN)
) (
    input  rsa_op_e         op,
    input  logic [XLEN-1:0] reg_src,
    input  logic [AW-1:0]   imm_src,
    output logic [AW-1:0]   amt
);

    // Select the distance source; only the low AW bits of reg_src matter.
    always_comb begin
        if (op == OPC_SHR_REG) begin
            amt = reg_src[AW-1:0];
        end else begin
            amt = imm_src;
        end
    end

endmodule

// File: rtl/rsa_round_shr.sv
// Module: combinational arithmetic right shift with round-half-up.
// For a distance s > 0 the operand is widened by one sign bit and shifted
// right by s-1, so the most significant dropped bit sits at bit 0. One is
// then added and a final halving drops that bit. A zero distance passes
// the operand through. It assumes amt < XLEN, which the field width
// guarantees.
module rsa_round_shr #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [XLEN-1:0] operand,
    input  logic [AW-1:0]   amt,
    output logic [XLEN-1:0] shifted
);

    logic signed [XLEN:0] wide;
    logic signed [XLEN:0] part;
    logic signed [XLEN:0] bumped;

    // Widen, pre-shift, add the rounding one, then halve.
    always_comb begin
        wide   = {operand[XLEN-1], operand};
        part   = wide >>> (amt - AW'(1));
        bumped = part + (XLEN+1)'(1);
        if (amt == '0) begin
            shifted = operand;
        end else begin
            shifted = XLEN'(bumped >>> 1);
        end
    end

endmodule

// File: rtl/rsa_round_avg.sv
// Module: combinational rounded signed average.
// Both operands are widened by one sign bit, summed with a rounding one,
// and halved. The guard bit means no operand pair can overflow.
module rsa_round_avg #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic [XLEN-1:0] mean
);

    logic signed [XLEN:0] total;

    // Guarded sum plus one, then arithmetic halving back to XLEN bits.
    always_comb begin
        total = {lhs[XLEN-1], lhs} + {rhs[XLEN-1], rhs} + (XLEN+1)'(1);
        mean  = XLEN'(total >>> 1);
    end

endmodule

// File: rtl/round_shift_avg.sv
// Module: top of the rounding shift / average unit.
// It decodes the opcode, picks the shift distance, selects the datapath
// result and registers it with a valid flag one cycle after the request.
// It assumes XLEN is 32 or 64 and uses a synchronous active-low reset.
module round_shift_avg
    import rsa_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int AW  = amt_width(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [AW-1:0]   imm_amt,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);

    rsa_op_e         op_e;
    logic [AW-1:0]   amt;
    logic [XLEN-1:0] shr_res;
    logic [XLEN-1:0] avg_res;
    logic [XLEN-1:0] next_res;
    logic            is_shift;

    // Interpret the raw opcode bits as the shared enum.
    always_comb begin
        op_e     = rsa_op_e'(op);
        is_shift = (op_e == OPC_SHR_REG) || (op_e == OPC_SHR_IMM);
    end

    rsa_amount_sel #(.XLEN(XLEN)) u_amt (
        .op      (op_e),
        .reg_src (src_b),
        .imm_src (imm_amt),
        .amt     (amt)
    );

    rsa_round_shr #(.XLEN(XLEN), .AW(AW)) u_shr (
        .operand (src_a),
        .amt     (amt),
        .shifted (shr_res)
    );

    rsa_round_avg #(.XLEN(XLEN)) u_avg (
        .lhs  (src_a),
        .rhs  (src_b),
        .mean (avg_res)
    );

    // Choose the datapath output for the opcode; the reserved code gives zero.
    always_comb begin
        unique case (op_e)
            OPC_SHR_REG, OPC_SHR_IMM: next_res = shr_res;
            OPC_AVG:                  next_res = avg_res;
            default:                  next_res = '0;
        endcase
    end

    // Output register: clear on reset, load on a valid request, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_zero_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift && amt == '0) |=> (result == $past(src_a)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift && !src_a[XLEN-1]) |=> !result[XLEN-1]);

    assert_avg_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OPC_AVG) |=>
        (($signed(result) >= $signed($past(src_a)) || $signed(result) >= $signed($past(src_b))) &&
         ($signed(result) <= $signed($past(src_a)) || $signed(result) <= $signed($past(src_b)))));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OPC_NONE) |=> (result == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(result));

endmodule

// File: tb/round_shift_avg_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the rounding shift / average unit at XLEN=32.
// It drives inputs on falling edges and samples one falling edge later,
// half a cycle after the output register loads.
module round_shift_avg_bench;

    localparam int XLEN = 32;
    localparam int AW   = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [1:0]      op;
    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] src_b;
    logic [AW-1:0]   imm_amt;
    logic            out_valid;
    logic [XLEN-1:0] result;

    int tests_run = 0;
    int tests_failed = 0;

    always #10 clk = ~clk;

    round_shift_avg #(.XLEN(XLEN)) u_round_shift_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm_amt   (imm_amt),
        .out_valid (out_valid),
        .result    (result)
    );

    // Reference: rounded shift computed on 64-bit signed integers.
    function automatic logic [XLEN-1:0] ref_shr(input logic [XLEN-1:0] a, input int s);
        longint v;
        v = longint'($signed(a));
        if (s == 0) return a;
        v = ((v >>> (s - 1)) + 64'sd1) >>> 1;
        return v[XLEN-1:0];
    endfunction

    // Reference: rounded average computed on 64-bit signed integers.
    function automatic logic [XLEN-1:0] ref_avg(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        longint v;
        v = (longint'($signed(a)) + longint'($signed(b)) + 64'sd1) >>> 1;
        return v[XLEN-1:0];
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        tests_run++;
        if (got !== exp) begin
            tests_failed++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Issue one request and return the registered result one edge later.
    task automatic issue(input logic [1:0] o, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input logic [AW-1:0] imm,
                         output logic [XLEN-1:0] res);
        @(negedge clk);
        in_valid = 1'b1; op = o; src_a = a; src_b = b; imm_amt = imm;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {31'd0, out_valid}, 32'd1);
        res = result;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; op = 2'b10;
        src_a = 32'h1234_5678; src_b = 32'h0; imm_amt = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_shift_patterns;
        logic [XLEN-1:0] r;
        logic [XLEN-1:0] vals [6] = '{32'd5, 32'd6, 32'hFFFF_FFFB, 32'hFFFF_FFFA, 32'h0001_2345, 32'hF00D_BEEF};
        for (int i = 0; i < 6; i++) begin
            for (int s = 1; s < 4; s++) begin
                issue(2'b00, vals[i], XLEN'(s), '0, r);
                check("R5 shift", r, ref_shr(vals[i], s));
            end
        end
        issue(2'b00, 32'h0000_0003, 32'd1, '0, r);
        check("R5 tie up", r, 32'd2);
        issue(2'b00, 32'hFFFF_FFFD, 32'd1, '0, r);
        check("R5 neg tie", r, 32'hFFFF_FFFF);
    endtask

    task automatic t_min_all_amounts;
        logic [XLEN-1:0] r;
        for (int s = 0; s < 32; s++) begin
            issue(2'b00, 32'h8000_0000, XLEN'(s), '0, r);
            check("R5 min value", r, ref_shr(32'h8000_0000, s));
        end
    endtask

    task automatic t_zero_amount;
        logic [XLEN-1:0] r;
        issue(2'b00, 32'hDEAD_BEEF, 32'hFFFF_FFE0, '0, r);
        check("R4 zero reg", r, 32'hDEAD_BEEF);
        issue(2'b01, 32'h7FFF_FFFF, 32'd7, '0, r);
        check("R4 zero imm", r, 32'h7FFF_FFFF);
    endtask

    task automatic t_upper_bits;
        logic [XLEN-1:0] r;
        issue(2'b00, 32'h0000_1234, 32'hFFFF_FFE3, '0, r);
        check("R3 upper ignored", r, ref_shr(32'h0000_1234, 3));
    endtask

    task automatic t_imm_matches;
        logic [XLEN-1:0] r1;
        logic [XLEN-1:0] r2;
        for (int s = 1; s < 32; s += 6) begin
            issue(2'b00, 32'hC3A5_0F17, XLEN'(s), '0, r1);
            issue(2'b01, 32'hC3A5_0F17, 32'd0, AW'(s), r2);
            check("R6 imm equals reg", r2, r1);
            check("R6 imm value", r2, ref_shr(32'hC3A5_0F17, s));
        end
    endtask

    task automatic t_max_positive;
        logic [XLEN-1:0] r;
        issue(2'b00, 32'h7FFF_FFFF, 32'd1, '0, r);
        check("R7 max by one", r, 32'h4000_0000);
        issue(2'b01, 32'h7FFF_FFFF, 32'd0, 5'd31, r);
        check("R7 max by 31", r, 32'd1);
    endtask

    task automatic t_average;
        logic [XLEN-1:0] r;
        issue(2'b10, 32'h7FFF_FFFF, 32'h7FFF_FFFF, '0, r);
        check("R8 max max", r, 32'h7FFF_FFFF);
        issue(2'b10, 32'h8000_0000, 32'h8000_0000, '0, r);
        check("R8 min min", r, 32'h8000_0000);
        issue(2'b10, 32'h7FFF_FFFF, 32'h8000_0000, '0, r);
        check("R8 max min", r, 32'd0);
        issue(2'b10, 32'd3, 32'd4, '0, r);
        check("R8 half up", r, 32'd4);
        issue(2'b10, 32'hFFFF_FFFD, 32'hFFFF_FFFC, '0, r);
        check("R8 neg half", r, ref_avg(32'hFFFF_FFFD, 32'hFFFF_FFFC));
    endtask

    task automatic t_reserved;
        logic [XLEN-1:0] r;
        issue(2'b11, 32'h1111_1111, 32'h2222_2222, 5'd3, r);
        check("R9 reserved zero", r, 32'd0);
    endtask

    task automatic t_hold;
        logic [XLEN-1:0] r;
        issue(2'b10, 32'd100, 32'd201, '0, r);
        check("R8 avg", r, 32'd151);
        op = 2'b00; src_a = 32'hFFFF_0000; src_b = 32'd4;
        repeat (3) @(negedge clk);
        check("R10 hold", result, 32'd151);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_shift_patterns();
        t_min_all_amounts();
        t_zero_amount();
        t_upper_bits();
        t_imm_matches();
        t_max_positive();
        t_average();
        t_reserved();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule